// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers a vertical sync signal from a composite sync stream that has already been normalized so that sync pulses are low. Every low pulse is timed in units of a slow reference tick, supplied as a one-cycle clock enable, and its tick count is compared against a programmable 8-bit threshold. Horizontal sync and equalization pulses are shorter than the threshold, so they never cause a change. The broad serrated vertical pulses do exceed it, and they switch the separated vertical sync output on. The first later pulse that stays short switches it off again.

A presence flag reports that separated vertical sync activity has been seen recently. It is set whenever the separated output rises. It drops when no new rise occurs within a window of 2^TO_W reference ticks, which is about 2^17 ticks by default. The threshold must be chosen above the longest horizontal or equalization pulse width. At a 5 MHz tick a value of 32 corresponds to about 6.4 µs.

Top module: `csync_vsep`

## Requirements
- R1: While rst_n is low, and after its release until the first qualifying pulse, vs_out and present_out are 0.
- R2: A pulse's width is the number of clock cycles with tick = 1 while csync_n = 0, and the first low cycle counts. Cycles with tick = 0 add nothing.
- R3: vs_out is 1 two clocks after the cycle that carries the (thresh+1)-th tick of a low pulse. One clock after that cycle it still shows its earlier value. It then stays 1 for the rest of the pulse and after it.
- R4: A low pulse of at most thresh ticks never sets vs_out.
- R5: When vs_out is 1, a low pulse of at most thresh ticks clears it. In the first high cycle after the pulse vs_out still reads 1, and from the next cycle on it reads 0.
- R6: The width count saturates at 255 and does not wrap. A pulse of 260 ticks with thresh = 10 leaves vs_out at 1. With thresh = 255 no pulse sets vs_out.
- R7: present_out is 1 in the same cycle in which vs_out rises.
- R8: present_out falls two clocks after the tick that completes 2^TO_W - 1 ticks counted from the first cycle in which vs_out is high. A new rise of vs_out restarts this window. With a tick on every cycle, present_out reads 1 for 2^TO_W cycles starting at the rise and 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Composite sync, pulses low |
| tick | input | 1 | Reference tick enable, one cycle wide |
| thresh | input | CNT_W | Width threshold in ticks |
| vs_out | output | 1 | Separated vertical sync, active high |
| present_out | output | 1 | Recent vertical sync activity |

## Verification
Pulse lengths are swept from 1 to 30 cycles under tick periods of one, two and three cycles and two thresholds. Each length is applied once with the output previously low and once with it previously high. These patterns separate a count of clock cycles from a count of ticks, an off-by-one in the comparison, an early or late rise, and a failure to clear after a short pulse. Pulses of 260 and 300 ticks tell a saturating counter apart from a wrapping one, and reveal a comparison that could trigger at the largest threshold. A sequence of long and short pulses with a tick on every cycle, followed by a long idle gap, checks that the presence flag rises with the output, is renewed by a later rise, and drops exactly when its window expires.

// File: rtl/csync_vsep_pkg.sv
package csync_vsep_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2
    } edge_e;
endpackage

// File: rtl/csync_vsep_edge.sv
module csync_vsep_edge
    import csync_vsep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  csync_n,
    output edge_e edge_o,
    output logic  low_held_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = csync_n;
        if (!csync_n && st_q.prev)
            edge_o = EDGE_FALL;
        else if (csync_n && !st_q.prev)
            edge_o = EDGE_RISE;
        else
            edge_o = EDGE_NONE;
        low_held_o = !st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.prev <= 1'b1;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/csync_vsep_width.sv
module csync_vsep_width
    import csync_vsep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             csync_n,
    input  edge_e            edge_kind,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } width_st_t;

    width_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_kind == EDGE_FALL)
            st_d.cnt = tick ? CNT_ONE : '0;
        else if (!csync_n && tick && (st_q.cnt != CNT_MAX))
            st_d.cnt = st_q.cnt + CNT_ONE;
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.cnt <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/csync_vsep_presence.sv
module csync_vsep_presence #(
    parameter int TO_W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic present_o
);
    localparam logic [TO_W-1:0] T_MAX = '1;
    localparam logic [TO_W-1:0] T_ONE = TO_W'(1);

    typedef struct packed {
        logic            present;
        logic [TO_W-1:0] tcnt;
    } pres_st_t;

    pres_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.present = 1'b1;
            st_d.tcnt    = '0;
        end else begin
            if (tick && (st_q.tcnt != T_MAX))
                st_d.tcnt = st_q.tcnt + T_ONE;
            if (st_q.tcnt == T_MAX)
                st_d.present = 1'b0;
        end
        present_o = st_q.present;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.present <= 1'b0;
            st_q.tcnt    <= T_MAX;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/csync_vsep.sv
module csync_vsep
    import csync_vsep_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TO_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csync_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] thresh,
    output logic             vs_out,
    output logic             present_out
);
    typedef struct packed {
        logic vs;
    } top_st_t;

    top_st_t          st_d, st_q;
    edge_e            edge_w;
    logic             low_held_w;
    logic [CNT_W-1:0] cnt_w;
    logic             long_seen;
    logic             vs_start;

    csync_vsep_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .csync_n    (csync_n),
        .edge_o     (edge_w),
        .low_held_o (low_held_w)
    );

    csync_vsep_width #(.CNT_W(CNT_W)) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .csync_n   (csync_n),
        .edge_kind (edge_w),
        .cnt_o     (cnt_w)
    );

    always_comb begin
        st_d      = st_q;
        long_seen = low_held_w && (cnt_w > thresh);
        if (long_seen)
            st_d.vs = 1'b1;
        else if (edge_w == EDGE_RISE)
            st_d.vs = 1'b0;
        vs_start = st_d.vs && !st_q.vs;
        vs_out   = st_q.vs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.vs <= 1'b0;
        else
            st_q <= st_d;
    end

    csync_vsep_presence #(.TO_W(TO_W)) u_pres (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (vs_start),
        .present_o (present_out)
    );
endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk
    import csync_vsep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] thresh,
    input logic             vs_out,
    input logic             present_out,
    input logic [CNT_W-1:0] cnt,
    input edge_e            edge_kind,
    input logic             low_held
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!vs_out && !present_out));

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && edge_kind != EDGE_FALL) |=> $stable(cnt));

    a_r3_set_on_long: assert property (@(posedge clk) disable iff (!rst_n)
        (low_held && cnt > thresh) |=> vs_out);

    a_r4_rise_needs_long: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_out) |-> $past(low_held && cnt > thresh));

    a_r5_clear_at_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_out) |-> $past(edge_kind == EDGE_RISE));

    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && edge_kind != EDGE_FALL) |=> cnt == CNT_MAX);

    a_r7_present_with_vs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_out) |-> present_out);

    a_r8_no_drop_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present_out) |-> !$rose(vs_out));
endmodule

bind csync_vsep csync_vsep_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .thresh      (thresh),
    .vs_out      (vs_out),
    .present_out (present_out),
    .cnt         (cnt_w),
    .edge_kind   (edge_w),
    .low_held    (low_held_w)
);

// File: tb/csync_vsep_tb_top.sv
`timescale 1ns/1ps
module csync_vsep_tb_top;
    localparam int TO_W = 6;
    localparam int TMAX = (1 << TO_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csync_n = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] thresh = 8'd3;
    logic       vs_out;
    logic       present_out;

    int   n_chk = 0;
    int   n_bad = 0;
    int   gcyc = 0;
    int   since = 0;
    logic vs_s = 1'b0;
    logic pr_s = 1'b0;
    logic vs_prev = 1'b0;
    logic ever = 1'b0;
    logic pchk = 1'b0;
    logic vs_exp = 1'b0;
    logic last_tk = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    csync_vsep #(.CNT_W(8), .TO_W(TO_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .csync_n     (csync_n),
        .tick        (tick),
        .thresh      (thresh),
        .vs_out      (vs_out),
        .present_out (present_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, gcyc);
        end
    endtask

    // Sample the outputs of the interval about to be driven, then drive it.
    task automatic step(input logic cs, input int per);
        @(negedge clk);
        vs_s = vs_out;
        pr_s = present_out;
        if (vs_s && !vs_prev) begin
            ever  = 1'b1;
            since = 0;
        end else if (since < 1000000) begin
            since++;
        end
        if (pchk)
            check((vs_s && !vs_prev) ? "R7" : "R8", pr_s, ever && (since <= TMAX));
        vs_prev = vs_s;
        csync_n = cs;
        tick    = ((gcyc % per) == 0);
        last_tk = tick;
        gcyc++;
    endtask

    task automatic do_reset();
        ever    = 1'b0;
        vs_prev = 1'b0;
        since   = 0;
        rst_n   = 1'b0;
        repeat (3) step(1'b1, 1);
        check("R1", vs_s, 1'b0);
        check("R1", pr_s, 1'b0);
        rst_n  = 1'b1;
        vs_exp = 1'b0;
        repeat (3) step(1'b1, 1);
        check("R1", vs_s, 1'b0);
        check("R1", pr_s, 1'b0);
    endtask

    // One low pulse of len cycles followed by three high cycles.
    task automatic pulse(input int len, input int per, input int th, input bit dochk);
        int   cnt = 0;
        int   j = -1;
        logic old = vs_exp;
        thresh = th[7:0];
        for (int i = 0; i < len; i++) begin
            step(1'b0, per);
            if (dochk) begin
                if (j < 0)          check("R4", vs_s, old);
                else if (i == j + 1) check("R3", vs_s, old);
                else                check("R3", vs_s, 1'b1);
            end
            if (last_tk && cnt < 255) begin
                cnt++;
                if (cnt == th + 1) j = i;  // R2: only ticked low cycles count
            end
        end
        for (int m = 0; m < 3; m++) begin
            step(1'b1, per);
            if (dochk) begin
                if (j >= 0)
                    check("R3", vs_s, ((len + m) >= j + 2) ? 1'b1 : old);
                else if (m == 0)
                    check("R5", vs_s, old);
                else
                    check(old ? "R5" : "R4", vs_s, 1'b0);
            end
        end
        vs_exp = (j >= 0);
    endtask

    initial begin
        do_reset();

        // R7 / R8: presence flag with a tick every cycle
        pchk = 1'b1;
        pulse(8, 1, 3, 1);
        pulse(2, 1, 3, 1);
        pulse(8, 1, 3, 1);
        repeat (80) step(1'b1, 1);
        pulse(8, 1, 3, 1);
        repeat (5) step(1'b1, 1);
        pchk = 1'b0;

        // R2..R5: sweep of thresholds, tick periods, pulse lengths, prior state
        for (int t = 0; t < 2; t++) begin
            for (int per = 1; per <= 3; per++) begin
                for (int len = 1; len <= 30; len++) begin
                    for (int old = 0; old < 2; old++) begin
                        int th = (t == 0) ? 3 : 7;
                        if (old == 1) pulse((th + 2) * per + 2, per, th, 0);
                        else          pulse(1, per, th, 0);
                        pulse(len, per, th, 1);
                    end
                end
            end
        end

        // R6: saturation of the width count
        pulse(2, 1, 10, 0);
        pulse(260, 1, 10, 1);
        check("R6", vs_s, 1'b1);
        pulse(2, 1, 10, 0);
        check("R6", vs_s, 1'b0);
        pulse(300, 1, 255, 1);
        check("R6", vs_s, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule